// File: doc/BRIEF.md
# Hysteretic Transport-Stream FIFO with Stuffing Insertion

This block is the front end of an asynchronous-serial transport-stream serializer. Payload bytes arrive in bursts on a write clock and are stored in a 1024-entry dual-clock FIFO. A continuous byte clock drains the FIFO. That clock produces one output symbol on every edge: a payload byte, or the K28.5 comma (code 0xBC) with a control flag set when no payload is ready.

Both FIFO flags have programmable hysteresis. The empty flag latches when the pointers meet. It releases only after the stored level has grown past the empty offset, so payload leaves in bursts rather than one byte at a time. The full flag latches when the store holds 1024 bytes. It releases only after more than the full offset of locations have been freed again. A small register port on the byte clock sets both offsets and a bypass mode. In bypass mode the output follows a direct data input, and an external comma request decides insertion.

Write side rules: a byte moves on a rising `wr_clk` edge when `wr_valid` and `wr_ready` are both high. `wr_ready` is the inverse of `wr_full`. A byte offered while `wr_ready` is low is discarded, and the source need not hold it. The output side has no back-pressure: one symbol per `rd_clk` cycle.

Top module: `ts_hyst_fifo`

## Requirements
- R1: While `rst_n` is low, and after its release, the block shows `out_data`=0xBC, `out_k`=1, `rd_empty`=1, `wr_full`=0 and `wr_ready`=1.
- R2: While `rd_empty` is high in FIFO mode, every output symbol is 0xBC with `out_k`=1, and no byte is taken from the store.
- R3: Once empty, payload resumes only when the stored level exceeds the empty offset. Payload then leaves one byte per `rd_clk` until the store is empty. With offset 5, five stored bytes keep the output stuffing, and a sixth releases all six back to back.
- R4: Payload bytes leave in write order with `out_k`=0, with none lost or repeated. With empty offset 0, output starts as soon as one byte is stored.
- R5: `wr_full` goes high when 1024 bytes are stored, and `wr_ready` is always its inverse.
- R6: Bytes offered while `wr_full` is high are discarded and never appear at the output.
- R7: Once full, `wr_full` stays high until the number of free locations exceeds the full offset.
- R8: In FIFO mode `sync_in` has no effect on the output.
- R9: In bypass mode the output one `rd_clk` cycle later is 0xBC with `out_k`=1 when `sync_in` is high, and `byp_data` with `out_k`=0 otherwise. The store is not read in bypass mode.
- R10: A register write (`cfg_we` high at a `rd_clk` edge) uses these addresses: `cfg_addr`=0 loads the empty offset from `cfg_wdata`[9:0], 1 loads the full offset, and 2 loads bypass from `cfg_wdata`[0]. All three reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Burst write clock |
| rd_clk | input | 1 | Continuous byte clock; also clocks the register port |
| rst_n | input | 1 | Asynchronous active-low reset, released per domain through synchronizers |
| wr_valid | input | 1 | Write byte offered |
| wr_data | input | 8 | Write byte |
| wr_ready | output | 1 | Write side can take a byte |
| wr_full | output | 1 | Hysteretic full flag (write domain) |
| out_data | output | 8 | Output symbol byte |
| out_k | output | 1 | High when `out_data` is a control character |
| rd_empty | output | 1 | Hysteretic empty flag (byte-clock domain) |
| sync_in | input | 1 | External comma request, used only in bypass mode |
| byp_data | input | 8 | Direct data used in bypass mode (byte-clock domain) |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 10 | Register write data |

## Verification
The assertions take the full offset as quasi-static: it reaches the write domain through a plain multi-bit synchronizer, so it must not change while the write side is near full. They also take `sync_in`, `byp_data` and the register port as driven synchronously to `rd_clk`. The stimulus therefore writes each offset only while the store is idle or held in bypass, and drives every byte-clock input on the falling edge. Write-side stimulus is offered on the falling `wr_clk` edge, and a byte counts as accepted only when `wr_ready` was high before the rising edge that takes it. This keeps the expected queue in step with the handshake rule above.

// File: rtl/hf_pkg.sv
`timescale 1ns/1ps
package hf_pkg;
  localparam logic [7:0] K_STUFF = 8'hBC;
  localparam logic [1:0] CFG_EMPTY_OFF = 2'd0;
  localparam logic [1:0] CFG_FULL_OFF  = 2'd1;
  localparam logic [1:0] CFG_MODE      = 2'd2;
endpackage

// File: rtl/hf_sync.sv
`timescale 1ns/1ps
module hf_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/hf_cfg.sv
`timescale 1ns/1ps
module hf_cfg
  import hf_pkg::*;
#(
  parameter int OFF_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [1:0]       addr,
  input  logic [OFF_W-1:0] wdata,
  output logic [OFF_W-1:0] empty_off,
  output logic [OFF_W-1:0] full_off,
  output logic             bypass
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_off <= '0;
      full_off  <= '0;
      bypass    <= 1'b0;
    end else if (we) begin
      unique case (addr)
        CFG_EMPTY_OFF: empty_off <= wdata;
        CFG_FULL_OFF:  full_off  <= wdata;
        CFG_MODE:      bypass    <= wdata[0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/hf_wr_ctrl.sv
`timescale 1ns/1ps
module hf_wr_ctrl #(
  parameter int ADDR_W = 10,
  localparam int PTR_W = ADDR_W + 1,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [PTR_W-1:0]  rgray_sync,
  input  logic [ADDR_W-1:0] full_off,
  output logic              wr_en,
  output logic [PTR_W-1:0]  wptr,
  output logic [PTR_W-1:0]  wgray,
  output logic [PTR_W-1:0]  free,
  output logic              full
);
  function automatic logic [PTR_W-1:0] from_gray(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PTR_W-1:0] rptr_b, used, free_after, wptr_nx;
  logic             full_d;

  assign rptr_b     = from_gray(rgray_sync);
  assign used       = wptr - rptr_b;
  assign free       = PTR_W'(DEPTH) - used;
  assign wr_en      = wr_valid && !full;
  assign free_after = free - PTR_W'(wr_en);
  assign wptr_nx    = wptr + PTR_W'(wr_en);

  always_comb begin
    if (free_after == '0)                   full_d = 1'b1;
    else if (free_after > PTR_W'(full_off)) full_d = 1'b0;
    else                                    full_d = full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      wgray <= '0;
      full  <= 1'b0;
    end else begin
      wptr  <= wptr_nx;
      wgray <= wptr_nx ^ (wptr_nx >> 1);
      full  <= full_d;
    end
  end
endmodule

// File: rtl/hf_rd_ctrl.sv
`timescale 1ns/1ps
module hf_rd_ctrl
  import hf_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  localparam int PTR_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PTR_W-1:0]  wgray_sync,
  input  logic [ADDR_W-1:0] empty_off,
  input  logic              bypass,
  input  logic              sync_in,
  input  logic [DATA_W-1:0] byp_data,
  input  logic [DATA_W-1:0] mem_q,
  output logic [PTR_W-1:0]  rptr,
  output logic [PTR_W-1:0]  rgray,
  output logic [PTR_W-1:0]  level,
  output logic              empty,
  output logic [DATA_W-1:0] out_data,
  output logic              out_k
);
  function automatic logic [PTR_W-1:0] from_gray(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PTR_W-1:0] wptr_b, level_after, rptr_nx;
  logic             rd_en, empty_d;

  assign wptr_b      = from_gray(wgray_sync);
  assign level       = wptr_b - rptr;
  assign rd_en       = !empty && !bypass;
  assign level_after = level - PTR_W'(rd_en);
  assign rptr_nx     = rptr + PTR_W'(rd_en);

  always_comb begin
    if (level_after == '0)                    empty_d = 1'b1;
    else if (level_after > PTR_W'(empty_off)) empty_d = 1'b0;
    else                                      empty_d = empty;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr     <= '0;
      rgray    <= '0;
      empty    <= 1'b1;
      out_data <= K_STUFF;
      out_k    <= 1'b1;
    end else begin
      rptr  <= rptr_nx;
      rgray <= rptr_nx ^ (rptr_nx >> 1);
      empty <= empty_d;
      if (bypass) begin
        out_k    <= sync_in;
        out_data <= sync_in ? K_STUFF : byp_data;
      end else if (rd_en) begin
        out_k    <= 1'b0;
        out_data <= mem_q;
      end else begin
        out_k    <= 1'b1;
        out_data <= K_STUFF;
      end
    end
  end
endmodule

// File: rtl/ts_hyst_fifo.sv
`timescale 1ns/1ps
module ts_hyst_fifo #(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 8,
  parameter int SYNC_STG = 2,
  localparam int PTR_W   = ADDR_W + 1,
  localparam int DEPTH   = 1 << ADDR_W
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              wr_full,
  output logic [DATA_W-1:0] out_data,
  output logic              out_k,
  output logic              rd_empty,
  input  logic              sync_in,
  input  logic [DATA_W-1:0] byp_data,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata
);
  logic              wr_rst_n, rd_rst_n, wr_en, bypass;
  logic [PTR_W-1:0]  wptr, wgray, wgray_s, wr_free;
  logic [PTR_W-1:0]  rptr, rgray, rgray_s, rd_level;
  logic [ADDR_W-1:0] empty_off, full_off, full_off_w;
  logic [DATA_W-1:0] mem [DEPTH];

  hf_sync #(.W(1), .STAGES(SYNC_STG)) u_wrst (
    .clk(wr_clk), .rst_n(rst_n), .d(1'b1), .q(wr_rst_n));
  hf_sync #(.W(1), .STAGES(SYNC_STG)) u_rrst (
    .clk(rd_clk), .rst_n(rst_n), .d(1'b1), .q(rd_rst_n));

  hf_cfg #(.OFF_W(ADDR_W)) u_cfg (
    .clk(rd_clk), .rst_n(rd_rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .empty_off(empty_off), .full_off(full_off),
    .bypass(bypass));

  hf_sync #(.W(PTR_W), .STAGES(SYNC_STG)) u_wp2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_s));
  hf_sync #(.W(PTR_W), .STAGES(SYNC_STG)) u_rp2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_s));
  hf_sync #(.W(ADDR_W), .STAGES(SYNC_STG)) u_foff (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(full_off), .q(full_off_w));

  hf_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .wr_valid(wr_valid),
    .rgray_sync(rgray_s), .full_off(full_off_w), .wr_en(wr_en),
    .wptr(wptr), .wgray(wgray), .free(wr_free), .full(wr_full));

  always_ff @(posedge wr_clk) begin
    if (wr_en) mem[wptr[ADDR_W-1:0]] <= wr_data;
  end

  hf_rd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .wgray_sync(wgray_s),
    .empty_off(empty_off), .bypass(bypass), .sync_in(sync_in),
    .byp_data(byp_data), .mem_q(mem[rptr[ADDR_W-1:0]]), .rptr(rptr),
    .rgray(rgray), .level(rd_level), .empty(rd_empty),
    .out_data(out_data), .out_k(out_k));

  assign wr_ready = !wr_full;
endmodule

// File: rtl/hf_chk.sv
`timescale 1ns/1ps
module hf_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  localparam int PTR_W = ADDR_W + 1,
  localparam int DEPTH = 1 << ADDR_W
) (
  input logic              wr_clk,
  input logic              rd_clk,
  input logic              wr_rst_n,
  input logic              rd_rst_n,
  input logic              wr_full,
  input logic              wr_ready,
  input logic [PTR_W-1:0]  wptr,
  input logic [PTR_W-1:0]  wr_free,
  input logic [ADDR_W-1:0] full_off_w,
  input logic              rd_empty,
  input logic [PTR_W-1:0]  rd_level,
  input logic [ADDR_W-1:0] empty_off,
  input logic              bypass,
  input logic              out_k,
  input logic [DATA_W-1:0] out_data
);
  // R2
  stuff_code_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    out_k |-> out_data == 8'hBC);

  // R2
  empty_stuff_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_empty && !bypass) |=> out_k);

  // R3
  empty_release_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $fell(rd_empty) |-> $past(rd_level) > $past(PTR_W'(empty_off)));

  // R4
  no_overflow_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_level <= PTR_W'(DEPTH));

  // R6
  full_drop_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_full |=> $stable(wptr));

  // R7
  full_release_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $fell(wr_full) |-> $past(wr_free) > $past(PTR_W'(full_off_w)));

  // R5
  ready_inv_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_ready != wr_full);
endmodule

bind ts_hyst_fifo hf_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .wr_rst_n(wr_rst_n), .rd_rst_n(rd_rst_n),
  .wr_full(wr_full), .wr_ready(wr_ready), .wptr(wptr), .wr_free(wr_free),
  .full_off_w(full_off_w), .rd_empty(rd_empty), .rd_level(rd_level),
  .empty_off(empty_off), .bypass(bypass), .out_k(out_k), .out_data(out_data));

// File: tb/ts_hyst_fifo_bench.sv
`timescale 1ns/1ps
module ts_hyst_fifo_bench;
  logic       wr_clk = 1'b0, rd_clk = 1'b0, rst_n = 1'b0;
  logic       wr_valid = 1'b0, sync_in = 1'b0, cfg_we = 1'b0;
  logic [7:0] wr_data = '0, byp_data = '0;
  logic [1:0] cfg_addr = '0;
  logic [9:0] cfg_wdata = '0;
  logic       wr_ready, wr_full, out_k, rd_empty;
  logic [7:0] out_data;

  always #2.5 rd_clk = ~rd_clk;
  always #3.5 wr_clk = ~wr_clk;

  ts_hyst_fifo u_ts_hyst_fifo (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_ready(wr_ready), .wr_full(wr_full),
    .out_data(out_data), .out_k(out_k), .rd_empty(rd_empty),
    .sync_in(sync_in), .byp_data(byp_data), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata));

  logic [7:0] exp_q[$];
  int  checks = 0, fails = 0, pay_cnt = 0, run = 0, last_run = 0;
  bit  mon_on = 0, mon_bypass = 0, done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge rd_clk) begin
    logic [7:0] e;
    if (mon_on && !mon_bypass) begin
      if (!out_k) begin
        if (exp_q.size() == 0) chk(0, "R4 unexpected payload", int'(out_data), -1);
        else begin
          e = exp_q.pop_front();
          chk(out_data === e, "R4 payload order", int'(out_data), int'(e));
        end
        pay_cnt++;
        run++;
      end else begin
        chk(out_data === 8'hBC, "R2 stuffing code", int'(out_data), 8'hBC);
        if (run > 0) last_run = run;
        run = 0;
      end
    end
  end

  task automatic host_wr(input logic [1:0] a, input logic [9:0] d);
    @(negedge rd_clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge rd_clk);
    cfg_we = 1'b0;
    @(posedge rd_clk);
    if (a == 2'd2) mon_bypass = d[0];
  endtask

  task automatic push_bytes(input int n, input logic [7:0] base);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      while (!wr_ready) @(negedge wr_clk);
      wr_valid = 1'b1;
      wr_data  = base + 8'(i);
      exp_q.push_back(wr_data);
    end
    @(negedge wr_clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_rd(input int n);
    repeat (n) @(negedge rd_clk);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    int b0;
    // R1: reset state, while held and after release
    wait_rd(3);
    chk(out_data === 8'hBC, "R1 out_data in reset", int'(out_data), 8'hBC);
    chk(out_k === 1'b1, "R1 out_k in reset", int'(out_k), 1);
    chk(rd_empty === 1'b1, "R1 rd_empty in reset", int'(rd_empty), 1);
    chk(wr_full === 1'b0, "R1 wr_full in reset", int'(wr_full), 0);
    rst_n = 1'b1;
    wait_rd(6);
    chk(out_k === 1'b1 && out_data === 8'hBC, "R1 stuffing after reset", int'(out_data), 8'hBC);
    chk(wr_ready === 1'b1, "R1 wr_ready after reset", int'(wr_ready), 1);
    chk(rd_empty === 1'b1, "R1 rd_empty after reset", int'(rd_empty), 1);
    mon_on = 1;

    // R4, R8: offset 0 streaming with sync_in held high
    sync_in = 1'b1;
    push_bytes(20, 8'h10);
    wait_rd(60);
    chk(exp_q.size() == 0, "R8 all bytes delivered with sync_in high", exp_q.size(), 0);
    chk(pay_cnt == 20, "R4 payload count", pay_cnt, 20);
    sync_in = 1'b0;

    // R3, R10: empty offset 5
    host_wr(2'd0, 10'd5);
    b0 = pay_cnt;
    push_bytes(5, 8'h40);
    wait_rd(60);
    chk(pay_cnt == b0, "R3 held at level equal to offset", pay_cnt - b0, 0);
    chk(rd_empty === 1'b1, "R2 empty flag held", int'(rd_empty), 1);
    push_bytes(1, 8'h45);
    wait_rd(60);
    chk(pay_cnt == b0 + 6, "R10 offset release count", pay_cnt - b0, 6);
    chk(last_run == 6, "R3 back-to-back burst", last_run, 6);

    // R9: bypass
    host_wr(2'd0, 10'd0);
    host_wr(2'd1, 10'd100);
    byp_data = 8'h3C;
    host_wr(2'd2, 10'd1);
    wait_rd(2);
    chk(out_data === 8'h3C && out_k === 1'b0, "R9 bypass data", int'({out_k, out_data}), 8'h3C);
    sync_in = 1'b1;
    wait_rd(2);
    chk(out_data === 8'hBC && out_k === 1'b1, "R9 bypass comma", int'({out_k, out_data}), 9'h1BC);
    sync_in = 1'b0;

    // R5, R6, R7: fill in bypass, then drain
    b0 = pay_cnt;
    push_bytes(1024, 8'h00);
    chk(wr_full === 1'b1, "R5 full at 1024", int'(wr_full), 1);
    for (int i = 0; i < 3; i++) begin
      chk(wr_ready === 1'b0, "R6 ready low while full", int'(wr_ready), 0);
      wr_valid = 1'b1;
      wr_data  = 8'hEE;
      @(negedge wr_clk);
    end
    wr_valid = 1'b0;
    host_wr(2'd2, 10'd0);
    while (!wr_ready) @(negedge wr_clk);
    chk(pay_cnt - b0 >= 101, "R7 full held past offset", pay_cnt - b0, 101);
    wait_rd(1200);
    chk(exp_q.size() == 0, "R6 queue drained", exp_q.size(), 0);
    chk(pay_cnt - b0 == 1024, "R6 no dropped byte delivered", pay_cnt - b0, 1024);
    chk(rd_empty === 1'b1 && wr_full === 1'b0, "R5 idle flags", int'({rd_empty, wr_full}), 2);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R4 watchdog expired: actual hung expected finished");
      summary();
      $finish;
    end
  end
endmodule